// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator with Shared Period

This block produces two pulse-width modulated outputs from one free-running cycle counter. A single base-period value sets the cycle length for both channels, and each channel compares the counter against its own duty-period value. Both values are loaded as "count minus one". The cycle therefore lasts base+1 counts. A normal channel is high for duty+1 counts at the start of every cycle.

A channel can be switched off, run normal (active high) or run inverted, which gives the complement of the normal waveform. A duty value at or above the base value saturates the channel to a constant level. A global run enable gates the counter. Period values written while the counter runs wait in shadow registers and take effect together when the counter wraps to zero, so no partial pulse is produced. Configuration comes in over a plain write-strobe port. Every output is registered.

Top module: `dual_pwm_gen`

## Requirements
- R1: With run_en high, the counter steps 0, 1, ..., base and then wraps to 0, so one cycle lasts base+1 clocks for any base value from 0 to 65535.
- R2: A channel in normal mode (mode code 1) is high while the counter is at most its duty value, so it is high for duty+1 clocks at the start of each cycle and low for the rest.
- R3: When a channel's duty value is greater than or equal to the base value, the channel is constantly high in normal mode and constantly low in inverted mode.
- R4: A duty value of 0 gives a one-clock high pulse at counter value 0 in every cycle, not a constant low.
- R5: A channel in inverted mode (mode code 2) outputs the complement of the normal-mode waveform for the same counter and duty value.
- R6: A channel whose mode code is 0 or 3 outputs low regardless of the counter.
- R7: While run_en is low the counter holds its value, and the outputs keep the level that value gives.
- R8: A base or duty value written while the counter runs is held in a shadow register. The active values are loaded from the shadows only on a clock edge where run_en is high and the counter equals the active base value, so the counter is then 0.
- R9: Synchronous reset clears the counter, all shadow and active period values and the outputs to 0, and sets both modes to off.
- R10: A write with wr_en high stores wr_data at that edge. Address 0 is the base value, address 1 the channel 0 duty, address 2 the channel 1 duty, and address 3 the modes (bits 1:0 for channel 0, bits 3:2 for channel 1). A mode write shows at the outputs after the next edge.
- R11: The two channels keep independent duty values and modes while sharing the one counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Global enable for the cycle counter |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 2 | Configuration address (0 base, 1 and 2 duty, 3 modes) |
| wr_data | input | 16 | Configuration write data |
| pwm_out | output | 2 | Registered channel outputs, bit n is channel n |

## Verification
Each output level is due one clock after the edge at which the counter held the value that selects it. A mode write therefore shows after the second edge. A base or duty write shows only from the first cycle after the next wrap. The driver keeps a step-by-step model of the counter, the shadow values and the modes that follows the requirements. At every edge it queues the level each channel must show after that edge. The monitor compares the outputs at the following falling edge. Phases cover hold with run_en low, mid-cycle rewrites, duty 0, saturation above and at the base value, off and inverted modes, and a reset in the middle of a run.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF     = 2'd0,
    MODE_NORMAL  = 2'd1,
    MODE_INVERT  = 2'd2,
    MODE_OFF_ALT = 2'd3
  } pwm_mode_e;

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CNT_W-1:0]              wr_data,
  input  logic                          load,
  output logic [CNT_W-1:0]              base_act,
  output logic [NUM_CH-1:0][CNT_W-1:0]  duty_act,
  output logic [NUM_CH-1:0][MODE_W-1:0] mode_q
);

  localparam int BASE_ADDR = 0;
  localparam int MODE_ADDR = NUM_CH + 1;

  logic [CNT_W-1:0] base_sh;

  // Shadow of the shared base value; copied to the active copy at wrap.
  always_ff @(posedge clk) begin
    if (rst) begin
      base_sh <= '0;
    end else if (wr_en && wr_addr == ADDR_W'(BASE_ADDR)) begin
      base_sh <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_act <= '0;
    end else if (load) begin
      base_act <= base_sh;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CNT_W-1:0] duty_sh;

    always_ff @(posedge clk) begin
      if (rst) begin
        duty_sh <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(c + 1)) begin
        duty_sh <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        duty_act[c] <= '0;
      end else if (load) begin
        duty_act[c] <= duty_sh;
      end
    end

    // Mode changes act at once; only period values wait for the wrap.
    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q[c] <= MODE_OFF;
      end else if (wr_en && wr_addr == ADDR_W'(MODE_ADDR)) begin
        mode_q[c] <= wr_data[MODE_W*c +: MODE_W];
      end
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [CNT_W-1:0] base_act,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);

  // The greater-or-equal test also recovers from any out-of-range count.
  assign wrap = run_en && (cnt_q >= base_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else if (run_en) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  duty,
  output logic              pwm_q
);

  logic      in_pulse;
  logic      pwm_d;
  pwm_mode_e mode_e;

  assign mode_e   = pwm_mode_e'(mode);
  assign in_pulse = (cnt <= duty);

  always_comb begin
    case (mode_e)
      MODE_NORMAL: pwm_d = in_pulse;
      MODE_INVERT: pwm_d = ~in_pulse;
      default:     pwm_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
    end
  end

endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
  import pwm_gen_pkg::*;
#(
  parameter  int CNT_W  = 16,
  parameter  int NUM_CH = 2,
  localparam int ADDR_W = $clog2(NUM_CH + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [NUM_CH-1:0] pwm_out
);

  logic [CNT_W-1:0]              cnt_q;
  logic                          wrap;
  logic [CNT_W-1:0]              base_act;
  logic [NUM_CH-1:0][CNT_W-1:0]  duty_act;
  logic [NUM_CH-1:0][MODE_W-1:0] mode_q;

  pwm_cfg_regs #(
    .CNT_W  (CNT_W),
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .load     (wrap),
    .base_act (base_act),
    .duty_act (duty_act),
    .mode_q   (mode_q)
  );

  pwm_timebase #(
    .CNT_W (CNT_W)
  ) u_tb (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .base_act (base_act),
    .cnt_q    (cnt_q),
    .wrap     (wrap)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_out
    pwm_channel #(
      .CNT_W (CNT_W)
    ) u_ch (
      .clk   (clk),
      .rst   (rst),
      .mode  (mode_q[c]),
      .cnt   (cnt_q),
      .duty  (duty_act[c]),
      .pwm_q (pwm_out[c])
    );
  end

endmodule

// File: rtl/dual_pwm_gen_checker.sv
module dual_pwm_gen_checker
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          run_en,
  input logic [NUM_CH-1:0]             pwm_out,
  input logic [CNT_W-1:0]              cnt,
  input logic [CNT_W-1:0]              base_act,
  input logic [NUM_CH-1:0][CNT_W-1:0]  duty_act,
  input logic [NUM_CH-1:0][MODE_W-1:0] mode
);

  logic seen_rst = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    cnt <= base_act);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    !run_en |=> $stable(cnt));

  assert_shadow_R8: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (!run_en || cnt != base_act) |=> ($stable(base_act) && $stable(duty_act)));

  assert_reset_R9: assert property (@(posedge clk) disable iff (!seen_rst)
    rst |=> (pwm_out == '0 && cnt == '0 && base_act == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_pulse_start_R4: assert property (@(posedge clk) disable iff (rst || !seen_rst)
      (mode[c] == MODE_NORMAL && cnt == '0) |=> pwm_out[c]);

    assert_sat_high_R3: assert property (@(posedge clk) disable iff (rst || !seen_rst)
      (mode[c] == MODE_NORMAL && duty_act[c] >= base_act) |=> pwm_out[c]);

    assert_sat_low_R3: assert property (@(posedge clk) disable iff (rst || !seen_rst)
      (mode[c] == MODE_INVERT && duty_act[c] >= base_act) |=> !pwm_out[c]);

    assert_off_low_R6: assert property (@(posedge clk) disable iff (rst || !seen_rst)
      (mode[c] == MODE_OFF || mode[c] == MODE_OFF_ALT) |=> !pwm_out[c]);
  end

endmodule

bind dual_pwm_gen dual_pwm_gen_checker #(
  .CNT_W  (CNT_W),
  .NUM_CH (NUM_CH)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .run_en   (run_en),
  .pwm_out  (pwm_out),
  .cnt      (cnt_q),
  .base_act (base_act),
  .duty_act (duty_act),
  .mode     (mode_q)
);

// File: tb/dual_pwm_gen_tb.sv
module dual_pwm_gen_tb;

  localparam time CLK_PER = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  pwm_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  // Requirement-level state of the block as the driver tracks it.
  logic [15:0] s_cnt, s_bact, s_bsh;
  logic [15:0] s_dact [2];
  logic [15:0] s_dsh  [2];
  logic [1:0]  s_mode [2];

  dual_pwm_gen u_dut (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_out (pwm_out)
  );

  always #(CLK_PER / 2) clk = ~clk;

  // R2 normal, R5 inverted, R6 codes 0 and 3 off.
  function automatic logic level(input logic [1:0] m, input logic [15:0] c,
                                 input logic [15:0] d);
    case (m)
      2'd1:    return (c <= d);
      2'd2:    return !(c <= d);
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic r, input logic run, input logic we,
                      input logic [1:0] a, input logic [15:0] d, input string tag);
    logic [1:0] e;
    @(negedge clk);
    rst = r; run_en = run; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    if (r) begin
      e = 2'b00;
      s_cnt = 0; s_bact = 0; s_bsh = 0;
      for (int k = 0; k < 2; k++) begin
        s_dact[k] = 0; s_dsh[k] = 0; s_mode[k] = 2'd0;
      end
    end else begin
      for (int k = 0; k < 2; k++) e[k] = level(s_mode[k], s_cnt, s_dact[k]);
      if (run) begin
        if (s_cnt >= s_bact) begin
          s_cnt = 0; s_bact = s_bsh;
          for (int k = 0; k < 2; k++) s_dact[k] = s_dsh[k];
        end else begin
          s_cnt = s_cnt + 16'd1;
        end
      end
      if (we) begin
        case (a)
          2'd0: s_bsh = d;
          2'd1: s_dsh[0] = d;
          2'd2: s_dsh[1] = d;
          default: begin s_mode[0] = d[1:0]; s_mode[1] = d[3:2]; end
        endcase
      end
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic run_for(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, 2'd0, 16'd0, tag);
  endtask

  task automatic idle_for(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 2'd0, 16'd0, tag);
  endtask

  task automatic wr(input logic run, input logic [1:0] a, input logic [15:0] d,
                    input string tag);
    step(1'b0, run, 1'b1, a, d, tag);
  endtask

  // Monitor: each queued level is due after the edge it was queued at.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (pwm_out !== e) begin
        n_bad++;
        $display("FAIL %s: pwm_out actual %b expected %b at %0t", t, pwm_out, e, $time);
      end
    end
  end

  initial begin
    step(1'b1, 1'b0, 1'b0, 2'd0, 16'd0, "R9 reset");
    step(1'b1, 1'b0, 1'b0, 2'd0, 16'd0, "R9 reset");
    idle_for(3, "R9 after reset");
    run_for(4, "R9 modes off after reset");

    // R10 map: base 9, duty0 3, duty1 6, ch0 normal, ch1 inverted.
    wr(1'b0, 2'd0, 16'd9, "R10 base write");
    wr(1'b0, 2'd1, 16'd3, "R10 duty0 write");
    wr(1'b0, 2'd2, 16'd6, "R10 duty1 write");
    wr(1'b0, 2'd3, 16'h0009, "R10 mode write");
    idle_for(2, "R10 mode at outputs");
    run_for(35, "R1 R2 R5 R11 waveform");

    idle_for(10, "R7 hold");
    run_for(6, "R7 resume");

    // R8: mid-cycle rewrite of base and duty, then R4 duty 0.
    wr(1'b1, 2'd0, 16'd4, "R8 base rewrite mid-cycle");
    run_for(2, "R8 old values still active");
    wr(1'b1, 2'd1, 16'd0, "R8 duty rewrite mid-cycle");
    run_for(30, "R4 R8 one-count pulse");

    // R3: duty equal to base (ch0 normal), duty above base (ch1 inverted).
    wr(1'b1, 2'd1, 16'd4, "R3 duty at base");
    wr(1'b1, 2'd2, 16'd9, "R3 duty above base");
    run_for(25, "R3 saturation");

    // R6: codes 0 and 3 both off.
    wr(1'b1, 2'd3, 16'h000C, "R6 off modes");
    run_for(12, "R6 outputs low");

    // R1 R2 with a long cycle: base 199, duty 119.
    wr(1'b1, 2'd0, 16'd199, "R1 long base");
    wr(1'b1, 2'd1, 16'd119, "R2 long duty");
    wr(1'b1, 2'd2, 16'd0, "R11 duty1 zero");
    wr(1'b1, 2'd3, 16'h0009, "R5 modes");
    run_for(420, "R1 R2 R5 R11 long cycle");

    step(1'b1, 1'b1, 1'b0, 2'd0, 16'd0, "R9 reset mid-run");
    run_for(6, "R9 cleared state");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run state actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule